// File: doc/BRIEF.md
# Operand Bypass and Pipeline Interlock Controller

This combinational controller sits beside the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register indices of the instruction being decoded, and at the destination index and write enable of each older instruction in execute, memory and writeback. For each source it picks where the operand should come from: the register file or one of the older pipeline registers. The youngest matching producer always wins, and register zero is never treated as a producer.

It also drives the pipeline control. If a load in execute feeds a source of the instruction in decode, the fetch and decode registers hold for one cycle and a nop bubble goes into execute. The loaded value is then bypassed from memory on the next cycle. A taken branch resolved in execute redirects the PC and turns the two younger instructions into nops. That squash takes precedence over a load-use hold in the same cycle.

The register file writes in the first half of the cycle and reads in the second half. So by default a writeback match needs no bypass. A parameter can enable an explicit writeback path instead.

Top module: `fwd_hazard_unit`

## Requirements
- R1: A producer whose destination index is zero never causes a bypass select other than register file (code 0) and never causes a hold.
- R2: A producer whose write enable is low is ignored for both bypass and hold.
- R3: A used source that matches an enabled, nonzero execute destination selects execute (code 1).
- R4: When several stages match the same source, the youngest wins: execute before memory before writeback.
- R5: A used source whose only enabled match is in memory selects memory (code 2).
- R6: With the default parameters, a match only in writeback selects the register file (code 0), because the register file is read after its write in the same cycle.
- R7: A source flagged as unused selects the register file and cannot cause a hold.
- R8: A load in execute whose nonzero destination matches a used source raises `stall_fd_o` and `bubble_ex_o` for that cycle, with `flush_dec_o` and `redirect_o` low.
- R9: A taken branch raises `redirect_o`, `flush_dec_o` and `bubble_ex_o`, and forces `stall_fd_o` low even when a load-use hazard is present.
- R10: With no load-use hazard and no taken branch, `stall_fd_o`, `bubble_ex_o`, `flush_dec_o` and `redirect_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1_i | input | 5 | First source index of the decoding instruction |
| dec_rs1_use_i | input | 1 | First source is read by the instruction |
| dec_rs2_i | input | 5 | Second source index of the decoding instruction |
| dec_rs2_use_i | input | 1 | Second source is read by the instruction |
| ex_rd_i | input | 5 | Destination index in execute |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | 5 | Destination index in memory |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | 5 | Destination index in writeback |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| ex_br_taken_i | input | 1 | Branch in execute resolved taken |
| fwd_a_o | output | 2 | First operand source: 0 regfile, 1 execute, 2 memory, 3 writeback |
| fwd_b_o | output | 2 | Second operand source, same encoding |
| stall_fd_o | output | 1 | Hold fetch and decode registers |
| bubble_ex_o | output | 1 | Load a nop into the execute register |
| flush_dec_o | output | 1 | Load a nop into the decode register |
| redirect_o | output | 1 | Steer the PC to the branch target |

## Verification
A wrong comparison or a wrong priority in this unit shows up in the same cycle. The bypass select names the wrong stage, the dependent instruction computes with a stale value, and the error then reaches the register file two cycles later. A missed hold lets the consumer read a load result that does not exist yet. A wrong squash priority leaves a wrong-path instruction alive, or holds a PC that should have been redirected. Because the block is purely combinational, every such fault is visible at the ports on the cycle of the stimulus. The bench therefore compares every output against a scoreboard on every cycle, driving random index patterns biased toward collisions alongside directed corner cases.

// File: rtl/fwd_hz_pkg.sv
package fwd_hz_pkg;

    parameter int unsigned REG_AW  = 5;
    parameter int unsigned NUM_SRC = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } opnd_sel_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     wen;
    } writer_t;

    // true when an older writer produces the register a source reads
    function automatic logic writer_hits(writer_t w, reg_idx_t src);
        return w.wen && (w.rd != '0) && (w.rd == src);
    endfunction

endpackage

// File: rtl/fwd_src_sel.sv
module fwd_src_sel
    import fwd_hz_pkg::*;
#(
    parameter bit WB_BYPASS = 1'b0
) (
    input  reg_idx_t  src_i,
    input  logic      use_i,
    input  writer_t   ex_i,
    input  writer_t   mem_i,
    input  writer_t   wb_i,
    output opnd_sel_e sel_o
);
    logic hit_ex, hit_mem, hit_wb;

    assign hit_ex  = use_i && writer_hits(ex_i, src_i);
    assign hit_mem = use_i && writer_hits(mem_i, src_i);
    assign hit_wb  = use_i && writer_hits(wb_i, src_i);

    always_comb begin
        if (hit_ex)                  sel_o = SEL_EX;
        else if (hit_mem)            sel_o = SEL_MEM;
        else if (hit_wb && WB_BYPASS) sel_o = SEL_WB;
        else                         sel_o = SEL_RF;
    end

    always_comb begin
        if (src_i == '0)
            assert_zero_src_R1: assert (sel_o == SEL_RF)
                else $error("register zero selected a bypass");
        if (!use_i)
            assert_unused_src_R7: assert (sel_o == SEL_RF)
                else $error("unused source selected a bypass");
        if (sel_o == SEL_MEM)
            assert_mem_young_R4: assert (!(ex_i.wen && ex_i.rd == src_i))
                else $error("memory chosen over a matching execute writer");
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
    import fwd_hz_pkg::*;
(
    input  reg_idx_t [NUM_SRC-1:0] src_i,
    input  logic     [NUM_SRC-1:0] use_i,
    input  writer_t                ex_i,
    input  logic                   ex_load_i,
    output logic                   hazard_o
);
    logic [NUM_SRC-1:0] per_src;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign per_src[g] = use_i[g] && ex_load_i && writer_hits(ex_i, src_i[g]);
    end

    assign hazard_o = |per_src;

    always_comb begin
        if (hazard_o)
            assert_hz_needs_writer_R2: assert (ex_i.wen && ex_i.rd != '0)
                else $error("hold raised without a live load writer");
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl (
    input  logic load_use_i,
    input  logic br_taken_i,
    output logic stall_fd_o,
    output logic bubble_ex_o,
    output logic flush_dec_o,
    output logic redirect_o
);
    always_comb begin
        stall_fd_o  = 1'b0;
        bubble_ex_o = 1'b0;
        flush_dec_o = 1'b0;
        redirect_o  = 1'b0;
        if (br_taken_i) begin
            // squash both wrong-path slots; a held consumer dies too
            redirect_o  = 1'b1;
            flush_dec_o = 1'b1;
            bubble_ex_o = 1'b1;
        end else if (load_use_i) begin
            stall_fd_o  = 1'b1;
            bubble_ex_o = 1'b1;
        end
    end

    always_comb begin
        assert_squash_beats_hold_R9: assert ($onehot0({stall_fd_o, flush_dec_o}))
            else $error("hold and squash raised together");
        if (stall_fd_o)
            assert_hold_bubbles_R8: assert (bubble_ex_o && !redirect_o)
                else $error("hold without bubble or with redirect");
        if (!load_use_i && !br_taken_i)
            assert_quiet_R10: assert (!(stall_fd_o || bubble_ex_o || flush_dec_o))
                else $error("control raised with no hazard");
    end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_hz_pkg::*;
#(
    parameter bit WB_BYPASS = 1'b0
) (
    input  logic [REG_AW-1:0] dec_rs1_i,
    input  logic              dec_rs1_use_i,
    input  logic [REG_AW-1:0] dec_rs2_i,
    input  logic              dec_rs2_use_i,
    input  logic [REG_AW-1:0] ex_rd_i,
    input  logic              ex_wen_i,
    input  logic              ex_load_i,
    input  logic [REG_AW-1:0] mem_rd_i,
    input  logic              mem_wen_i,
    input  logic [REG_AW-1:0] wb_rd_i,
    input  logic              wb_wen_i,
    input  logic              ex_br_taken_i,
    output logic [1:0]        fwd_a_o,
    output logic [1:0]        fwd_b_o,
    output logic              stall_fd_o,
    output logic              bubble_ex_o,
    output logic              flush_dec_o,
    output logic              redirect_o
);
    writer_t                ex_w, mem_w, wb_w;
    reg_idx_t [NUM_SRC-1:0] srcs;
    logic     [NUM_SRC-1:0] uses;
    opnd_sel_e [NUM_SRC-1:0] sels;
    logic                   load_use;

    assign ex_w  = '{rd: ex_rd_i,  wen: ex_wen_i};
    assign mem_w = '{rd: mem_rd_i, wen: mem_wen_i};
    assign wb_w  = '{rd: wb_rd_i,  wen: wb_wen_i};
    assign srcs  = {dec_rs2_i, dec_rs1_i};
    assign uses  = {dec_rs2_use_i, dec_rs1_use_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        fwd_src_sel #(.WB_BYPASS(WB_BYPASS)) u_sel (
            .src_i (srcs[g]),
            .use_i (uses[g]),
            .ex_i  (ex_w),
            .mem_i (mem_w),
            .wb_i  (wb_w),
            .sel_o (sels[g])
        );
    end

    load_use_detect u_lud (
        .src_i     (srcs),
        .use_i     (uses),
        .ex_i      (ex_w),
        .ex_load_i (ex_load_i),
        .hazard_o  (load_use)
    );

    hazard_ctrl u_ctrl (
        .load_use_i  (load_use),
        .br_taken_i  (ex_br_taken_i),
        .stall_fd_o  (stall_fd_o),
        .bubble_ex_o (bubble_ex_o),
        .flush_dec_o (flush_dec_o),
        .redirect_o  (redirect_o)
    );

    assign fwd_a_o = sels[0];
    assign fwd_b_o = sels[1];

    always_comb begin
        if (dec_rs1_use_i && ex_wen_i && ex_rd_i != '0 && ex_rd_i == dec_rs1_i)
            assert_ex_pick_R3: assert (fwd_a_o == 2'(SEL_EX))
                else $error("execute match not bypassed");
        if (fwd_a_o == 2'(SEL_EX))
            assert_wen_gate_R2: assert (ex_wen_i)
                else $error("bypass from non-writing execute instruction");
        if (stall_fd_o)
            assert_hold_src_R8: assert (ex_load_i)
                else $error("hold without a load in execute");
    end
endmodule

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic [4:0] rs1, rs2, exrd, memrd, wbrd;
    logic u1, u2, exw, exl, memw, wbw, br;
    logic [1:0] fa, fb;
    logic st, bub, fl, rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    fwd_hazard_unit u_dut (
        .dec_rs1_i(rs1), .dec_rs1_use_i(u1), .dec_rs2_i(rs2), .dec_rs2_use_i(u2),
        .ex_rd_i(exrd), .ex_wen_i(exw), .ex_load_i(exl),
        .mem_rd_i(memrd), .mem_wen_i(memw), .wb_rd_i(wbrd), .wb_wen_i(wbw),
        .ex_br_taken_i(br),
        .fwd_a_o(fa), .fwd_b_o(fb), .stall_fd_o(st), .bubble_ex_o(bub),
        .flush_dec_o(fl), .redirect_o(rd)
    );

    function automatic logic [1:0] exp_sel(logic [4:0] s, logic u);
        if (!u || s == 5'd0) return 2'd0;
        if (exw && exrd == s) return 2'd1;
        if (memw && memrd == s) return 2'd2;
        return 2'd0;  // writeback reaches decode through the register file
    endfunction

    function automatic logic exp_lu();
        return exl && exw && exrd != 5'd0 &&
               ((u1 && rs1 == exrd) || (u2 && rs2 == exrd));
    endfunction

    task automatic chk(string tag, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic idle();
        rs1 = 0; rs2 = 0; u1 = 0; u2 = 0; exrd = 0; exw = 0; exl = 0;
        memrd = 0; memw = 0; wbrd = 0; wbw = 0; br = 0;
    endtask

    task automatic check_all(string tag);
        logic lu;
        @(negedge clk);
        lu = exp_lu();
        chk(tag, "fwd_a", int'(fa), int'(exp_sel(rs1, u1)));
        chk(tag, "fwd_b", int'(fb), int'(exp_sel(rs2, u2)));
        chk(tag, "stall", int'(st), int'(lu && !br));
        chk(tag, "bubble", int'(bub), int'(lu || br));
        chk(tag, "flush", int'(fl), int'(br));
        chk(tag, "redirect", int'(rd), int'(br));
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        @(posedge clk);
        check_all("R10");                       // quiescent outputs all zero
        // R1: register zero as load destination
        idle(); rs1 = 0; u1 = 1; exrd = 0; exw = 1; exl = 1; check_all("R1");
        // R2: disabled writer
        idle(); rs1 = 5; u1 = 1; exrd = 5; exl = 1; memrd = 5; check_all("R2");
        // R3: execute match
        idle(); rs1 = 9; u1 = 1; exrd = 9; exw = 1; check_all("R3");
        @(negedge clk); chk("R3", "fwd_a direct", int'(fa), 1); @(posedge clk);
        // R4: all three match on rs2
        idle(); rs2 = 7; u2 = 1; exrd = 7; exw = 1; memrd = 7; memw = 1;
        wbrd = 7; wbw = 1; check_all("R4");
        @(negedge clk); chk("R4", "fwd_b direct", int'(fb), 1); @(posedge clk);
        // R5: memory over writeback
        idle(); rs2 = 7; u2 = 1; memrd = 7; memw = 1; wbrd = 7; wbw = 1;
        check_all("R5");
        @(negedge clk); chk("R5", "fwd_b direct", int'(fb), 2); @(posedge clk);
        // R6: writeback only
        idle(); rs1 = 12; u1 = 1; wbrd = 12; wbw = 1; check_all("R6");
        // R7: unused source matching a load
        idle(); rs1 = 5; u1 = 0; exrd = 5; exw = 1; exl = 1; check_all("R7");
        // R8: load-use on rs2
        idle(); rs1 = 3; u1 = 1; rs2 = 6; u2 = 1; exrd = 6; exw = 1; exl = 1;
        check_all("R8");
        @(negedge clk); chk("R8", "stall direct", int'(st), 1); @(posedge clk);
        // R9: branch with load-use
        br = 1; check_all("R9");
        @(negedge clk); chk("R9", "stall under squash", int'(st), 0); @(posedge clk);
        idle(); br = 1; check_all("R9");
        // random, indices biased to collide
        for (int i = 0; i < 3000; i++) begin
            rs1 = 5'($urandom_range(0, 3)); rs2 = 5'($urandom_range(0, 3));
            exrd = 5'($urandom_range(0, 3)); memrd = 5'($urandom_range(0, 3));
            wbrd = 5'($urandom_range(0, 3));
            if (($urandom % 8) == 0) rs1 = 5'($urandom);
            u1 = 1'($urandom); u2 = 1'($urandom); exw = 1'($urandom);
            exl = 1'($urandom); memw = 1'($urandom); wbw = 1'($urandom);
            br = (($urandom % 6) == 0);
            check_all("R4-rand");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule